// File: doc/BRIEF.md
# Metered Random Word Server with Autonomous Reseed

This block sits between a conditioned-entropy stage and a request port seen by software. While a reseed is pending it takes two 128-bit conditioned samples, joins them into one 256-bit seed, and offers that seed to an expansion stage. After the expansion stage accepts the seed, the block takes 128-bit expanded blocks from that stage into a small buffer. It then serves 16-, 32- or 64-bit values from the buffer. Each request gets a response on the next cycle, and every response carries a success flag. A request never waits.

The block counts the blocks taken under the current seed. When the count reaches a hard budget, the block stops taking blocks and starts a new reseed without being asked. Requests fail while the reseed is pending and while the upstream health fault input is high. The consumer then retries or falls back to another source.

Top module: `rng_word_server`

## Requirements
- R1: `reqWidth` picks the output size: code 0 gives 16 bits, code 1 gives 32 bits and code 2 gives 64 bits. Code 3 always fails. A served value is zero-extended into the 64-bit `rspData`.
- R2: Every cycle with `reqValid` high produces exactly one response. `rspValid` is high for one cycle, on the cycle after the request.
- R3: A successful response has `rspOk`=1. Its value is the next unused bits of the oldest buffered block, taken from bit 0 upward in 16-bit lanes. A block leaves the buffer once its top lane is used.
- R4: A failed response has `rspOk`=0 and `rspData`=0. A failed request leaves the buffer and the read position unchanged.
- R5: `sampleReady` is high only while a reseed is pending and fewer than two samples are held. `seedValid` rises once two samples are held. `seedData` carries the first sample in bits 255:128 and the second sample in bits 127:0.
- R6: At most BLOCK_LIMIT (default 511) blocks are taken per seed. The block that reaches the limit drops `blkReady` and raises `reseedReq` on the next cycle. When a new seed is accepted, the count restarts at zero.
- R7: A request fails while `reseedReq` is high or while `healthFault` is high, even if the buffer holds data.
- R8: A request is served from the oldest block only if it fits in that block's remaining lanes. If it does not fit and a second block is buffered, the remainder of the oldest block is discarded and the value comes from lane 0 of the next block. If it does not fit and only one block is buffered, the request fails.
- R9: After synchronous reset: `reseedReq`=1, `sampleReady`=1, `seedValid`=0, `seedData`=0, `blkReady`=0, `rspValid`=0. The buffer is empty.
- R10: The buffer holds BUF_DEPTH blocks, and `blkReady` is low while the buffer is full. Blocks still buffered when a new seed is accepted are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleValid | input | 1 | Conditioned sample offered |
| sampleData | input | 128 | Conditioned sample |
| sampleReady | output | 1 | Sample taken this cycle when valid |
| seedValid | output | 1 | Seed offered to expansion stage |
| seedData | output | 256 | Seed: first sample high, second low |
| seedReady | input | 1 | Expansion stage accepts the seed |
| blkValid | input | 1 | Expanded block offered |
| blkData | input | 128 | Expanded block |
| blkReady | output | 1 | Block taken this cycle when valid |
| healthFault | input | 1 | Upstream health fault active |
| reqValid | input | 1 | Word request |
| reqWidth | input | 2 | Size code: 0=16, 1=32, 2=64, 3=invalid |
| rspValid | output | 1 | Response strobe, one cycle after a request |
| rspOk | output | 1 | 1 = value valid, 0 = unavailable |
| rspData | output | 64 | Random value, zero-extended |
| reseedReq | output | 1 | Reseed pending |

## Verification
The bench uses the default values: BLOCK_LIMIT = 511 and BUF_DEPTH = 2. The full per-seed budget therefore runs in about a thousand cycles, so the bench can check the exact block at which the reseed starts. A two-entry buffer fills after only two pushes, which exercises back-pressure and spanning requests that skip to the next block. It also allows a spanning request to fail when only one block is held.

// File: rtl/rng_word_pkg.sv
package rng_word_pkg;
  localparam int BLOCK_BITS = 128;
  localparam int LANE_BITS  = 16;
  localparam int LANES      = BLOCK_BITS / LANE_BITS;
  localparam int LANE_IDX_W = $clog2(LANES);

  typedef struct packed {
    logic                  sampleTake;
    logic                  seedClear;
    logic                  blkPush;
    logic                  rspLoad;
    logic                  rspOk;
    logic                  useNext;
    logic [LANE_IDX_W-1:0] rdLane;
  } dp_ctl_t;

  function automatic logic [LANE_IDX_W:0] laneCount(input logic [1:0] code);
    case (code)
      2'd0:    laneCount = (LANE_IDX_W+1)'(1);
      2'd1:    laneCount = (LANE_IDX_W+1)'(2);
      2'd2:    laneCount = (LANE_IDX_W+1)'(4);
      default: laneCount = '0;
    endcase
  endfunction
endpackage

// File: rtl/rng_word_ctrl.sv
module rng_word_ctrl
  import rng_word_pkg::*;
#(
  parameter int BLOCK_LIMIT = 511,
  parameter int BUF_DEPTH   = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sampleValid,
  output logic                         sampleReady,
  output logic                         seedValid,
  input  logic                         seedReady,
  input  logic                         blkValid,
  output logic                         blkReady,
  input  logic                         healthFault,
  input  logic                         reqValid,
  input  logic [1:0]                   reqWidth,
  output logic                         rspValid,
  output logic                         rspOk,
  output logic                         reseedReq,
  output logic [$clog2(BUF_DEPTH)-1:0] wrIdx,
  output logic [$clog2(BUF_DEPTH)-1:0] headIdx,
  output dp_ctl_t                      ctl
);
  localparam int PTR_W = $clog2(BUF_DEPTH);
  localparam int OCC_W = PTR_W + 1;
  localparam int CNT_W = $clog2(BLOCK_LIMIT + 1);

  logic             pending;
  logic [1:0]       seedCnt;
  logic [CNT_W-1:0] blkCnt;
  logic [PTR_W-1:0] headPtr, tailPtr;
  logic [OCC_W-1:0] occ;
  logic [LANE_IDX_W-1:0] laneOff;

  logic seedAccept, blkAccept, sampleAccept;
  logic widthOk, fits, useNext, canServe, doPop, lastUse;
  logic [LANE_IDX_W:0] nLanes, laneSum;

  always_comb begin
    sampleReady  = pending && (seedCnt < 2'd2);
    sampleAccept = sampleValid && sampleReady;
    seedValid    = pending && (seedCnt == 2'd2);
    seedAccept   = seedValid && seedReady;
    blkReady     = !pending && (occ < OCC_W'(BUF_DEPTH)) && (blkCnt < CNT_W'(BLOCK_LIMIT));
    blkAccept    = blkValid && blkReady;
    nLanes       = laneCount(reqWidth);
    widthOk      = (nLanes != '0);
    laneSum      = {1'b0, laneOff} + nLanes;
    fits         = laneSum <= (LANE_IDX_W+1)'(LANES);
    lastUse      = laneSum == (LANE_IDX_W+1)'(LANES);
    useNext      = !fits;
    canServe     = reqValid && widthOk && !pending && !healthFault &&
                   (occ != '0) && (fits || occ >= OCC_W'(2));
    doPop        = canServe && (useNext || lastUse);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b1;
      seedCnt  <= '0;
      blkCnt   <= '0;
      headPtr  <= '0;
      tailPtr  <= '0;
      occ      <= '0;
      laneOff  <= '0;
      rspValid <= 1'b0;
      rspOk    <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspOk    <= canServe;
      if (sampleAccept) seedCnt <= seedCnt + 2'd1;
      if (seedAccept) begin
        pending <= 1'b0;
        seedCnt <= '0;
        blkCnt  <= '0;
        headPtr <= '0;
        tailPtr <= '0;
        occ     <= '0;
        laneOff <= '0;
      end else begin
        if (blkAccept) begin
          blkCnt  <= blkCnt + CNT_W'(1);
          tailPtr <= tailPtr + PTR_W'(1);
          if (blkCnt == CNT_W'(BLOCK_LIMIT - 1)) pending <= 1'b1;
        end
        if (doPop) headPtr <= headPtr + PTR_W'(1);
        occ <= occ + OCC_W'(blkAccept) - OCC_W'(doPop);
        if (canServe) begin
          if (useNext)      laneOff <= nLanes[LANE_IDX_W-1:0];
          else if (lastUse) laneOff <= '0;
          else              laneOff <= laneSum[LANE_IDX_W-1:0];
        end
      end
    end
  end

  always_comb begin
    reseedReq      = pending;
    wrIdx          = tailPtr;
    headIdx        = headPtr;
    ctl.sampleTake = sampleAccept;
    ctl.seedClear  = seedAccept;
    ctl.blkPush    = blkAccept;
    ctl.rspLoad    = reqValid;
    ctl.rspOk      = canServe;
    ctl.useNext    = useNext;
    ctl.rdLane     = useNext ? '0 : laneOff;
  end

  a_r2_rsp_next: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);
  a_r6_cnt_cap: assert property (@(posedge clk) disable iff (rst)
    blkCnt <= CNT_W'(BLOCK_LIMIT));
  a_r6_reseed_at_limit: assert property (@(posedge clk) disable iff (rst)
    (blkAccept && blkCnt == CNT_W'(BLOCK_LIMIT - 1)) |=> (reseedReq && !blkReady));
  a_r7_ok_needs_ready: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspOk) |-> $past(!pending && !healthFault));
  a_r10_occ_bound: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(BUF_DEPTH));
  a_r5_seed_hold: assert property (@(posedge clk) disable iff (rst)
    (seedValid && !seedReady) |=> seedValid);
endmodule

// File: rtl/rng_word_dp.sv
module rng_word_dp
  import rng_word_pkg::*;
#(
  parameter int BUF_DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  dp_ctl_t                      ctl,
  input  logic [$clog2(BUF_DEPTH)-1:0] wrIdx,
  input  logic [$clog2(BUF_DEPTH)-1:0] headIdx,
  input  logic [1:0]                   reqWidth,
  input  logic [BLOCK_BITS-1:0]        sampleData,
  input  logic [BLOCK_BITS-1:0]        blkData,
  output logic [2*BLOCK_BITS-1:0]      seedData,
  output logic [63:0]                  rspData
);
  localparam int PTR_W = $clog2(BUF_DEPTH);

  logic [BLOCK_BITS-1:0] bufMem [BUF_DEPTH];
  logic [PTR_W-1:0]      selIdx;
  logic [BLOCK_BITS-1:0] shifted;
  logic [63:0]           sliced;

  always_ff @(posedge clk) begin
    if (rst || ctl.seedClear) seedData <= '0;
    else if (ctl.sampleTake)  seedData <= {seedData[BLOCK_BITS-1:0], sampleData};
  end

  always_ff @(posedge clk) begin
    if (ctl.blkPush) bufMem[wrIdx] <= blkData;
  end

  always_comb begin
    selIdx  = ctl.useNext ? headIdx + PTR_W'(1) : headIdx;
    shifted = bufMem[selIdx] >> (ctl.rdLane * LANE_BITS);
    case (reqWidth)
      2'd0:    sliced = {48'd0, shifted[15:0]};
      2'd1:    sliced = {32'd0, shifted[31:0]};
      default: sliced = shifted[63:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)              rspData <= '0;
    else if (ctl.rspLoad) rspData <= ctl.rspOk ? sliced : '0;
  end

  a_r4_fail_zero: assert property (@(posedge clk) disable iff (rst)
    (ctl.rspLoad && !ctl.rspOk) |=> (rspData == '0));
  a_r1_short_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (ctl.rspLoad && reqWidth == 2'd0) |=> (rspData[63:16] == '0));
endmodule

// File: rtl/rng_word_server.sv
module rng_word_server
  import rng_word_pkg::*;
#(
  parameter int BLOCK_LIMIT = 511,
  parameter int BUF_DEPTH   = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sampleValid,
  input  logic [127:0] sampleData,
  output logic         sampleReady,
  output logic         seedValid,
  output logic [255:0] seedData,
  input  logic         seedReady,
  input  logic         blkValid,
  input  logic [127:0] blkData,
  output logic         blkReady,
  input  logic         healthFault,
  input  logic         reqValid,
  input  logic [1:0]   reqWidth,
  output logic         rspValid,
  output logic         rspOk,
  output logic [63:0]  rspData,
  output logic         reseedReq
);
  localparam int PTR_W = $clog2(BUF_DEPTH);

  dp_ctl_t          ctl;
  logic [PTR_W-1:0] wrIdx, headIdx;

  rng_word_ctrl #(.BLOCK_LIMIT(BLOCK_LIMIT), .BUF_DEPTH(BUF_DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .sampleValid(sampleValid), .sampleReady(sampleReady),
    .seedValid(seedValid), .seedReady(seedReady),
    .blkValid(blkValid), .blkReady(blkReady),
    .healthFault(healthFault),
    .reqValid(reqValid), .reqWidth(reqWidth),
    .rspValid(rspValid), .rspOk(rspOk), .reseedReq(reseedReq),
    .wrIdx(wrIdx), .headIdx(headIdx), .ctl(ctl)
  );

  rng_word_dp #(.BUF_DEPTH(BUF_DEPTH)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .wrIdx(wrIdx), .headIdx(headIdx), .reqWidth(reqWidth),
    .sampleData(sampleData), .blkData(blkData),
    .seedData(seedData), .rspData(rspData)
  );
endmodule

// File: tb/rng_word_server_tb.sv
module rng_word_server_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sampleValid = 1'b0;
  logic [127:0] sampleData = '0;
  logic         sampleReady, seedValid, blkReady, rspValid, rspOk, reseedReq;
  logic [255:0] seedData;
  logic         seedReady = 1'b0;
  logic         blkValid = 1'b0;
  logic [127:0] blkData = '0;
  logic         healthFault = 1'b0;
  logic         reqValid = 1'b0;
  logic [1:0]   reqWidth = 2'd0;
  logic [63:0]  rspData;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;

  rng_word_server u_dut (
    .clk(clk), .rst(rst),
    .sampleValid(sampleValid), .sampleData(sampleData), .sampleReady(sampleReady),
    .seedValid(seedValid), .seedData(seedData), .seedReady(seedReady),
    .blkValid(blkValid), .blkData(blkData), .blkReady(blkReady),
    .healthFault(healthFault),
    .reqValid(reqValid), .reqWidth(reqWidth),
    .rspValid(rspValid), .rspOk(rspOk), .rspData(rspData),
    .reseedReq(reseedReq)
  );

  always #2.5 clk = ~clk;

  localparam logic [127:0] K1 = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
  localparam logic [127:0] K2 = 128'h1f1e1d1c_1b1a1918_17161514_13121110;
  localparam logic [127:0] K3 = 128'h2f2e2d2c_2b2a2928_27262524_23222120;
  localparam logic [127:0] K4 = 128'h3f3e3d3c_3b3a3938_37363534_33323130;
  localparam logic [127:0] K5 = 128'h4f4e4d4c_4b4a4948_47464544_43424140;
  localparam logic [127:0] K6 = 128'h5f5e5d5c_5b5a5958_57565554_53525150;
  localparam logic [127:0] K7 = 128'h6f6e6d6c_6b6a6968_67666564_63626160;
  localparam logic [127:0] SA = 128'haaaa_0001_aaaa_0002_aaaa_0003_aaaa_0004;
  localparam logic [127:0] SB = 128'hbbbb_0001_bbbb_0002_bbbb_0003_bbbb_0004;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReq(string req, logic [1:0] w, logic expOk, logic [63:0] expData);
    reqValid = 1'b1;
    reqWidth = w;
    tick();
    reqValid = 1'b0;
    chk({req, " rspValid"}, 256'(rspValid), 256'(1));
    chk({req, " rspOk"}, 256'(rspOk), 256'(expOk));
    chk({req, " rspData"}, 256'(rspData), expOk ? 256'(expData) : 256'(0));
  endtask

  task automatic pushBlk(logic [127:0] d);
    blkValid = 1'b1;
    blkData  = d;
    while (!blkReady) tick();
    tick();
    blkValid = 1'b0;
  endtask

  task automatic giveSeed(logic [127:0] a, logic [127:0] b);
    sampleValid = 1'b1;
    sampleData  = a;
    tick();
    sampleData  = b;
    tick();
    sampleValid = 1'b0;
    chk("R5 seedValid", 256'(seedValid), 256'(1));
    chk("R5 sampleReady low", 256'(sampleReady), 256'(0));
    chk("R5 seed order", seedData, {a, b});
    seedReady = 1'b1;
    tick();
    seedReady = 1'b0;
    chk("R6 reseedReq cleared", 256'(reseedReq), 256'(0));
    chk("R6 blkReady after seed", 256'(blkReady), 256'(1));
  endtask

  task automatic t_reset();
    chk("R9 reseedReq", 256'(reseedReq), 256'(1));
    chk("R9 sampleReady", 256'(sampleReady), 256'(1));
    chk("R9 seedValid", 256'(seedValid), 256'(0));
    chk("R9 seedData", seedData, 256'(0));
    chk("R9 blkReady", 256'(blkReady), 256'(0));
    chk("R9 rspValid", 256'(rspValid), 256'(0));
    doReq("R7 req while pending", 2'd0, 1'b0, 64'd0);
  endtask

  task automatic t_slice();
    doReq("R4 empty buffer", 2'd2, 1'b0, 64'd0);
    pushBlk(K1);
    pushBlk(K2);
    doReq("R3 lane0 16b", 2'd0, 1'b1, {48'd0, K1[15:0]});
    doReq("R3 lane1 16b", 2'd0, 1'b1, {48'd0, K1[31:16]});
    doReq("R1 32b", 2'd1, 1'b1, {32'd0, K1[63:32]});
    doReq("R1 64b top", 2'd2, 1'b1, K1[127:64]);
    doReq("R1 code3 fails", 2'd3, 1'b0, 64'd0);
    doReq("R4 state kept after fail", 2'd2, 1'b1, K2[63:0]);
    doReq("R3 K2 32b", 2'd1, 1'b1, {32'd0, K2[95:64]});
  endtask

  task automatic t_span();
    pushBlk(K3);
    doReq("R8 skip to next block", 2'd2, 1'b1, K3[63:0]);
    doReq("R3 K3 top", 2'd2, 1'b1, K3[127:64]);
    pushBlk(K4);
    doReq("R3 K4 low", 2'd2, 1'b1, K4[63:0]);
    doReq("R3 K4 32b", 2'd1, 1'b1, {32'd0, K4[95:64]});
    doReq("R8 no next block fails", 2'd2, 1'b0, 64'd0);
    doReq("R4 offset kept", 2'd0, 1'b1, {48'd0, K4[111:96]});
    doReq("R3 K4 last lane", 2'd0, 1'b1, {48'd0, K4[127:112]});
  endtask

  task automatic t_health();
    pushBlk(K5);
    healthFault = 1'b1;
    doReq("R7 health fault", 2'd0, 1'b0, 64'd0);
    healthFault = 1'b0;
    doReq("R7 after fault clears", 2'd0, 1'b1, {48'd0, K5[15:0]});
    pushBlk(K6);
    chk("R10 buffer full", 256'(blkReady), 256'(0));
  endtask

  task automatic t_budget();
    int  accepted = 6;
    bit  saw510 = 0;
    while (accepted < 511) begin
      bit willTake;
      blkValid = 1'b1;
      blkData  = {96'd0, 32'(accepted)};
      reqValid = 1'b1;
      reqWidth = 2'd2;
      willTake = blkReady;
      tick();
      if (willTake) accepted++;
      if (accepted == 510 && !saw510) begin
        saw510 = 1;
        chk("R6 no reseed before limit", 256'(reseedReq), 256'(0));
      end
    end
    blkValid = 1'b0;
    reqValid = 1'b0;
    chk("R6 reseedReq at 511", 256'(reseedReq), 256'(1));
    chk("R6 blkReady low at 511", 256'(blkReady), 256'(0));
    chk("R5 sampleReady on reseed", 256'(sampleReady), 256'(1));
    doReq("R7 buffered but pending", 2'd0, 1'b0, 64'd0);
    giveSeed(~SA, ~SB);
    doReq("R10 old blocks dropped", 2'd0, 1'b0, 64'd0);
    pushBlk(K7);
    doReq("R6 serve after reseed", 2'd0, 1'b1, {48'd0, K7[15:0]});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    giveSeed(SA, SB);
    t_slice();
    t_span();
    t_health();
    t_budget();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule